// File: doc/BRIEF.md
# Serial NOR Flash Slave Emulator

This block stands in for a serial NOR flash device on a single-bit SPI bus in mode 0. An external master drives chip select, serial clock and data in, and reads data out. The block runs on a faster system clock and synchronizes the serial pins into that domain. It shifts in an 8-bit opcode, then a 24-bit address and data bytes where the command needs them. Behind the bus sits a small byte array divided into 256-byte pages grouped into sectors. The array follows NOR write rules: an erase sets bytes to FFh, and a program can only clear bits.

Program and erase are accepted only while the write-enable latch is set. Each one commits when chip select rises on a byte boundary. It then holds the busy flag for a fixed number of system clocks and clears the write-enable latch when it finishes. Program data is staged in a page buffer and merged into the array during the busy window. Any command that arrives while busy is ignored, except the two status reads.

Top module: `spi_nor_emu`

## Requirements
- R1: Opcode 90h with a 24-bit address returns identity bytes that alternate for as long as the clock runs. When address bit 0 is 0, the first byte is MFR_ID (default A5h) and the next is DEV_ID (default 17h). When address bit 0 is 1, the order starts with DEV_ID.
- R2: Opcode 06h sets the write-enable latch and 04h clears it; neither takes an address. Opcode 05h returns status byte {6'b0, WEL, BUSY}, with BUSY in bit 0 and WEL in bit 1. Opcode 35h returns SR2_VALUE (default 00h). Both status reads repeat their byte for as long as the clock runs.
- R3: Opcode 20h with an address sets every byte of the addressed sector to FFh (default sector 1 KB, that is 4 pages) and leaves the other sectors unchanged.
- R4: Opcode 02h writes each data byte as the bitwise AND of the new byte and the stored byte, so a stored 0 bit stays 0.
- R5: During a program, the column is the low 8 address bits. It increments after each byte and wraps to the start of the same 256-byte page.
- R6: When a program carries more bytes than fit in the page, a later byte written to the same column replaces the earlier one, and only the last value is merged.
- R7: A program or erase issued while WEL is 0 changes neither the array nor the status.
- R8: A committed program or erase holds BUSY for exactly BUSY_CYCLES system clocks. BUSY and WEL both clear when it ends.
- R9: Opcode 03h with an address streams bytes from consecutive addresses, crossing page boundaries, MSB first, each bit driven after a falling serial clock edge. While BUSY is set, every opcode other than 05h and 35h is ignored: data out stays high and the running operation goes on unaffected.
- R10: A program commits only if chip select rises after at least one whole data byte and with no partial byte pending. An erase commits only if chip select rises right after the third address byte. Any other rising chip select discards the command.
- R11: Address bits above the array size are ignored.
- R12: Reset clears WEL and BUSY. Data out is high whenever chip select has been high for a few system clocks.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n | input | 1 | Serial chip select, active low |
| sck | input | 1 | Serial clock, mode 0 |
| mosi | input | 1 | Serial data into the block |
| miso | output | 1 | Serial data out of the block |

## Verification
The assertions assume that the serial pins change slowly compared with the system clock. Each serial clock level and each chip-select level must last several system cycles, so that the synchronizers see every edge and mosi is settled when a rising edge is detected. The bench holds each serial clock phase for eight system cycles. It changes chip select only while the serial clock is low, and it separates commands by at least two half periods. It also relies on BUSY_CYCLES being at least the sector size, so that the erase walk fits inside the busy window. The parameter defaults satisfy this.

// File: rtl/spi_nor_emu_pkg.sv
package spi_nor_emu_pkg;
    typedef enum logic [2:0] {
        PH_IDLE, PH_OPCODE, PH_ADDR, PH_WDATA, PH_EHOLD, PH_RDATA, PH_DROP
    } phase_e;

    typedef enum logic [1:0] {JOB_NONE, JOB_ERASE, JOB_PROG} job_e;

    localparam logic [7:0] OPC_IDENT = 8'h90;
    localparam logic [7:0] OPC_WREN  = 8'h06;
    localparam logic [7:0] OPC_WRDI  = 8'h04;
    localparam logic [7:0] OPC_STAT1 = 8'h05;
    localparam logic [7:0] OPC_STAT2 = 8'h35;
    localparam logic [7:0] OPC_ERASE = 8'h20;
    localparam logic [7:0] OPC_PROG  = 8'h02;
    localparam logic [7:0] OPC_READ  = 8'h03;
endpackage

// File: rtl/spi_nor_emu_edges.sv
module spi_nor_emu_edges #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_n,
    input  logic sck,
    input  logic mosi,
    output logic sck_rise,
    output logic sck_fall,
    output logic cs_fall,
    output logic cs_rise,
    output logic mosi_s
);
    logic [STAGES:0] sck_q, cs_q, mosi_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sck_q  <= '0;
            cs_q   <= '1;
            mosi_q <= '0;
        end else begin
            sck_q  <= {sck_q[STAGES-1:0], sck};
            cs_q   <= {cs_q[STAGES-1:0], cs_n};
            mosi_q <= {mosi_q[STAGES-1:0], mosi};
        end
    end

    assign sck_rise = sck_q[STAGES-1] & ~sck_q[STAGES];
    assign sck_fall = ~sck_q[STAGES-1] & sck_q[STAGES];
    assign cs_rise  = cs_q[STAGES-1] & ~cs_q[STAGES];
    assign cs_fall  = ~cs_q[STAGES-1] & cs_q[STAGES];
    assign mosi_s   = mosi_q[STAGES-1];
endmodule

// File: rtl/spi_nor_emu_array.sv
module spi_nor_emu_array #(
    parameter int DEPTH = 4096,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [7:0]    wdata,
    input  logic [AW-1:0] raddr_a,
    output logic [7:0]    rdata_a,
    input  logic [AW-1:0] raddr_b,
    output logic [7:0]    rdata_b
);
    logic [7:0] cells [DEPTH];

    always_ff @(posedge clk) begin
        if (we) cells[waddr] <= wdata;
    end

    assign rdata_a = cells[raddr_a];
    assign rdata_b = cells[raddr_b];
endmodule

// File: rtl/spi_nor_emu_pgbuf.sv
module spi_nor_emu_pgbuf #(
    parameter int BYTES = 256,
    localparam int CW = $clog2(BYTES)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          we,
    input  logic [CW-1:0] waddr,
    input  logic [7:0]    wdata,
    input  logic [CW-1:0] raddr,
    output logic [7:0]    rdata,
    output logic          rvalid
);
    logic [7:0]       data_q [BYTES];
    logic [BYTES-1:0] valid_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   valid_q <= '0;
        else if (clr) valid_q <= '0;
        else if (we)  valid_q[waddr] <= 1'b1;
    end

    always_ff @(posedge clk) begin
        if (we) data_q[waddr] <= wdata;
    end

    assign rdata  = data_q[raddr];
    assign rvalid = valid_q[raddr];
endmodule

// File: rtl/spi_nor_emu.sv
module spi_nor_emu
    import spi_nor_emu_pkg::*;
#(
    parameter int         PAGE_BYTES   = 256,
    parameter int         SECTOR_PAGES = 4,
    parameter int         SECTORS      = 4,
    parameter int         BUSY_CYCLES  = 1200,
    parameter logic [7:0] MFR_ID       = 8'hA5,
    parameter logic [7:0] DEV_ID       = 8'h17,
    parameter logic [7:0] SR2_VALUE    = 8'h00
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_n,
    input  logic sck,
    input  logic mosi,
    output logic miso
);
    localparam int SECTOR_BYTES = PAGE_BYTES * SECTOR_PAGES;
    localparam int DEPTH = SECTOR_BYTES * SECTORS;
    localparam int AW  = $clog2(DEPTH);
    localparam int CW  = $clog2(PAGE_BYTES);
    localparam int SW  = $clog2(SECTOR_BYTES);
    localparam int BCW = $clog2(BUSY_CYCLES + 1);
    localparam logic [BCW-1:0] ERASE_LEN = BCW'(SECTOR_BYTES);
    localparam logic [BCW-1:0] PROG_LEN  = BCW'(PAGE_BYTES);
    localparam logic [BCW-1:0] LAST_CYC  = BCW'(BUSY_CYCLES - 1);

    typedef struct packed {
        phase_e         ph;
        logic [2:0]     bit_n;
        logic [7:0]     sh_in;
        logic [7:0]     opc;
        logic [1:0]     abyte;
        logic [23:0]    addr;
        logic [CW-1:0]  col;
        logic           got_data;
        logic [7:0]     sh_out;
        logic [2:0]     obit;
        logic           miso;
        logic           wel;
        logic           busy;
        job_e           job;
        logic [BCW-1:0] bcnt;
        logic [AW-1:0]  base;
    } emu_t;

    emu_t st_d, st_q;

    logic sck_rise, sck_fall, cs_fall, cs_rise, mosi_s;
    logic arr_we, pb_clr, pb_we, pb_valid;
    logic [AW-1:0] arr_waddr, walk_addr;
    logic [7:0] arr_wdata, rd_a, rd_b, pb_rdata, byte_in, src;
    logic busy_w, wel_w;

    spi_nor_emu_edges #(.STAGES(2)) u_edges (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .mosi(mosi),
        .sck_rise(sck_rise), .sck_fall(sck_fall), .cs_fall(cs_fall),
        .cs_rise(cs_rise), .mosi_s(mosi_s)
    );

    spi_nor_emu_array #(.DEPTH(DEPTH)) u_array (
        .clk(clk), .we(arr_we), .waddr(arr_waddr), .wdata(arr_wdata),
        .raddr_a(st_q.addr[AW-1:0]), .rdata_a(rd_a),
        .raddr_b(walk_addr), .rdata_b(rd_b)
    );

    spi_nor_emu_pgbuf #(.BYTES(PAGE_BYTES)) u_pgbuf (
        .clk(clk), .rst_n(rst_n), .clr(pb_clr), .we(pb_we),
        .waddr(st_q.col), .wdata(byte_in),
        .raddr(st_q.bcnt[CW-1:0]), .rdata(pb_rdata), .rvalid(pb_valid)
    );

    assign walk_addr = st_q.base + AW'(st_q.bcnt);
    assign byte_in   = {st_q.sh_in[6:0], mosi_s};

    always_comb begin
        case (st_q.opc)
            OPC_STAT1: src = {6'b0, st_q.wel, st_q.busy};
            OPC_STAT2: src = SR2_VALUE;
            OPC_IDENT: src = st_q.addr[0] ? DEV_ID : MFR_ID;
            default:   src = rd_a;
        endcase
    end

    always_comb begin
        st_d      = st_q;
        arr_we    = 1'b0;
        arr_waddr = walk_addr;
        arr_wdata = 8'hFF;
        pb_clr    = 1'b0;
        pb_we     = 1'b0;

        // background walk of a committed erase or program
        if (st_q.busy) begin
            st_d.bcnt = st_q.bcnt + BCW'(1);
            if (st_q.job == JOB_ERASE && st_q.bcnt < ERASE_LEN) begin
                arr_we = 1'b1;
            end else if (st_q.job == JOB_PROG && st_q.bcnt < PROG_LEN && pb_valid) begin
                arr_we    = 1'b1;
                arr_wdata = rd_b & pb_rdata;
            end
            if (st_q.bcnt == LAST_CYC) begin
                st_d.busy = 1'b0;
                st_d.wel  = 1'b0;
                st_d.job  = JOB_NONE;
            end
        end

        if (cs_rise) begin
            if (st_q.bit_n == 3'd0 &&
                ((st_q.ph == PH_WDATA && st_q.got_data) || st_q.ph == PH_EHOLD)) begin
                st_d.busy = 1'b1;
                st_d.bcnt = '0;
                if (st_q.ph == PH_EHOLD) begin
                    st_d.job  = JOB_ERASE;
                    st_d.base = {st_q.addr[AW-1:SW], SW'(0)};
                end else begin
                    st_d.job  = JOB_PROG;
                    st_d.base = {st_q.addr[AW-1:CW], CW'(0)};
                end
            end
            st_d.ph   = PH_IDLE;
            st_d.miso = 1'b1;
        end else if (cs_fall) begin
            st_d.ph    = PH_OPCODE;
            st_d.bit_n = '0;
            st_d.miso  = 1'b1;
        end else if (sck_rise && st_q.ph != PH_IDLE) begin
            st_d.sh_in = byte_in;
            st_d.bit_n = st_q.bit_n + 3'd1;
            case (st_q.ph)
                PH_OPCODE: if (st_q.bit_n == 3'd7) begin
                    st_d.opc      = byte_in;
                    st_d.abyte    = '0;
                    st_d.got_data = 1'b0;
                    st_d.obit     = '0;
                    st_d.ph       = PH_DROP;
                    if (!st_q.busy || byte_in == OPC_STAT1 || byte_in == OPC_STAT2) begin
                        case (byte_in)
                            OPC_WREN:             st_d.wel = 1'b1;
                            OPC_WRDI:             st_d.wel = 1'b0;
                            OPC_STAT1, OPC_STAT2: st_d.ph  = PH_RDATA;
                            OPC_IDENT, OPC_READ:  st_d.ph  = PH_ADDR;
                            OPC_ERASE:            if (st_q.wel) st_d.ph = PH_ADDR;
                            OPC_PROG: if (st_q.wel) begin
                                st_d.ph = PH_ADDR;
                                pb_clr  = 1'b1;
                            end
                            default: ;
                        endcase
                    end
                end
                PH_ADDR: if (st_q.bit_n == 3'd7) begin
                    st_d.addr  = {st_q.addr[15:0], byte_in};
                    st_d.abyte = st_q.abyte + 2'd1;
                    if (st_q.abyte == 2'd2) begin
                        st_d.col = byte_in[CW-1:0];
                        st_d.ph  = (st_q.opc == OPC_ERASE) ? PH_EHOLD :
                                   (st_q.opc == OPC_PROG)  ? PH_WDATA : PH_RDATA;
                    end
                end
                PH_WDATA: if (st_q.bit_n == 3'd7) begin
                    pb_we         = 1'b1;
                    st_d.col      = st_q.col + CW'(1);
                    st_d.got_data = 1'b1;
                end
                PH_EHOLD: st_d.ph = PH_DROP;
                default: ;
            endcase
        end else if (sck_fall && st_q.ph == PH_RDATA) begin
            st_d.obit = st_q.obit + 3'd1;
            if (st_q.obit == 3'd0) begin
                st_d.miso   = src[7];
                st_d.sh_out = {src[6:0], 1'b0};
                if (st_q.opc == OPC_READ || st_q.opc == OPC_IDENT)
                    st_d.addr = st_q.addr + 24'd1;
            end else begin
                st_d.miso   = st_q.sh_out[7];
                st_d.sh_out = {st_q.sh_out[6:0], 1'b0};
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q      <= '0;
            st_q.miso <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign miso   = st_q.miso;
    assign busy_w = st_q.busy;
    assign wel_w  = st_q.wel;
endmodule

// File: rtl/spi_nor_emu_chk.sv
module spi_nor_emu_chk #(
    parameter int BUSY_CYCLES = 1200
) (
    input logic clk,
    input logic rst_n,
    input logic cs_n,
    input logic miso,
    input logic busy,
    input logic wel
);
    logic [31:0] run_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    run_q <= '0;
        else if (busy) run_q <= run_q + 32'd1;
        else           run_q <= '0;
    end

    // R8
    busy_length_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> run_q == 32'(BUSY_CYCLES));

    // R8
    wel_clear_on_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> !wel);

    // R8
    busy_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> run_q < 32'(BUSY_CYCLES));

    // R7
    busy_needs_wel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(wel));

    // R9
    no_wel_set_while_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wel) |-> !$past(busy));

    // R12
    reset_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> (!busy && !wel));

    // R12
    idle_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_n && $past(cs_n) && $past(cs_n, 2) && $past(cs_n, 3) && $past(cs_n, 4)) |-> miso);
endmodule

bind spi_nor_emu spi_nor_emu_chk #(.BUSY_CYCLES(BUSY_CYCLES)) u_chk (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .miso(miso),
    .busy(busy_w), .wel(wel_w)
);

// File: tb/spi_nor_emu_test.sv
`timescale 1ns/1ps
module spi_nor_emu_test;
    localparam int  BUSY = 1200;
    localparam time HALF = 40;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cs_n = 1'b1;
    logic sck = 1'b0;
    logic mosi = 1'b0;
    logic miso;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    spi_nor_emu #(.BUSY_CYCLES(BUSY)) uut (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .mosi(mosi), .miso(miso)
    );

    // opcode, address, bytes to read, expected first, expected second
    localparam logic [55:0] VEC [8] = '{
        {8'h90, 24'h000000, 8'd2, 8'hA5, 8'h17},
        {8'h90, 24'h000001, 8'd2, 8'h17, 8'hA5},
        {8'h05, 24'h000000, 8'd1, 8'h00, 8'h00},
        {8'h35, 24'h000000, 8'd2, 8'h00, 8'h00},
        {8'h06, 24'h000000, 8'd0, 8'h00, 8'h00},
        {8'h05, 24'h000000, 8'd2, 8'h02, 8'h02},
        {8'h04, 24'h000000, 8'd0, 8'h00, 8'h00},
        {8'h05, 24'h000000, 8'd1, 8'h00, 8'h00}
    };

    task automatic check(input string tag, input logic [7:0] got, input logic [7:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic xfer(input logic [7:0] tx, output logic [7:0] rx);
        for (int i = 7; i >= 0; i--) begin
            mosi = tx[i];
            #HALF;
            rx[i] = miso;
            sck = 1'b1;
            #HALF;
            sck = 1'b0;
        end
    endtask

    task automatic cs_on();
        cs_n = 1'b0;
        #HALF;
    endtask

    task automatic cs_off();
        #HALF;
        cs_n = 1'b1;
        #(HALF * 2);
    endtask

    task automatic hdr(input logic [7:0] op, input logic [23:0] a);
        logic [7:0] d;
        xfer(op, d);
        xfer(a[23:16], d);
        xfer(a[15:8], d);
        xfer(a[7:0], d);
    endtask

    task automatic simple(input logic [7:0] op);
        logic [7:0] d;
        cs_on();
        xfer(op, d);
        cs_off();
    endtask

    task automatic status(input string tag, input logic [7:0] exp);
        logic [7:0] d;
        cs_on();
        xfer(8'h05, d);
        xfer(8'h00, d);
        cs_off();
        check(tag, d, exp);
    endtask

    task automatic read1(input string tag, input logic [23:0] a, input logic [7:0] exp);
        logic [7:0] d;
        cs_on();
        hdr(8'h03, a);
        xfer(8'h00, d);
        cs_off();
        check(tag, d, exp);
    endtask

    task automatic erase(input logic [23:0] a);
        simple(8'h06);
        cs_on();
        hdr(8'h20, a);
        cs_off();
    endtask

    task automatic settle();
        repeat (BUSY + 100) @(negedge clk);
    endtask

    initial begin
        repeat (180000) @(negedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: got hung expected finish");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        logic [7:0] d, r0, r1;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        check("R12 miso high while deselected", {7'b0, miso}, 8'h01);

        // table-driven identity and status vectors (R1, R2)
        foreach (VEC[k]) begin
            cs_on();
            xfer(VEC[k][55:48], d);
            if (VEC[k][55:48] == 8'h90) begin
                xfer(VEC[k][47:40], d);
                xfer(VEC[k][39:32], d);
                xfer(VEC[k][31:24], d);
            end
            r0 = 8'h00;
            r1 = 8'h00;
            if (VEC[k][23:16] > 0) xfer(8'h00, r0);
            if (VEC[k][23:16] > 1) xfer(8'h00, r1);
            cs_off();
            if (VEC[k][23:16] > 0) check("R1/R2 table byte0", r0, VEC[k][15:8]);
            if (VEC[k][23:16] > 1) check("R1/R2 table byte1", r1, VEC[k][7:0]);
        end

        // R3 erase sector 0, R8 busy timing
        erase(24'h000000);
        status("R8 busy and WEL just after commit", 8'h03);
        repeat (BUSY - 500) @(negedge clk);
        status("R8 still busy late in window", 8'h03);
        repeat (600) @(negedge clk);
        status("R8 busy and WEL cleared at end", 8'h00);
        read1("R3 erased first byte", 24'h000000, 8'hFF);
        read1("R3 erased last byte of sector", 24'h0003FF, 8'hFF);

        // R7 program without WEL
        cs_on();
        hdr(8'h02, 24'h000020);
        xfer(8'h00, d);
        cs_off();
        status("R7 no busy without WEL", 8'h00);
        read1("R7 array unchanged", 24'h000020, 8'hFF);

        // R5 page wrap: 32 bytes from column F0h
        simple(8'h06);
        cs_on();
        hdr(8'h02, 24'h0000F0);
        for (int i = 0; i < 32; i++) xfer(8'h30 + 8'(i), d);
        cs_off();
        settle();
        cs_on();
        hdr(8'h03, 24'h0000FE);
        xfer(8'h00, r0);
        xfer(8'h00, r1);
        xfer(8'h00, d);
        cs_off();
        check("R9 stream byte FEh", r0, 8'h3E);
        check("R9 stream byte FFh", r1, 8'h3F);
        check("R9 stream crosses into next page", d, 8'hFF);
        read1("R5 wrapped to page start", 24'h000000, 8'h40);

        // R4 AND merge
        simple(8'h06);
        cs_on();
        hdr(8'h02, 24'h000000);
        xfer(8'hF0, d);
        xfer(8'h0F, d);
        cs_off();
        settle();
        read1("R4 AND merge byte 0", 24'h000000, 8'h40);
        read1("R4 AND merge byte 1", 24'h000001, 8'h01);

        // R6 overflow overwrites earlier byte in buffer
        simple(8'h06);
        cs_on();
        hdr(8'h02, 24'h000300);
        xfer(8'h11, d);
        for (int i = 0; i < 255; i++) xfer(8'hFF, d);
        xfer(8'h22, d);
        cs_off();
        settle();
        read1("R6 last write wins", 24'h000300, 8'h22);

        // R10 partial byte aborts program
        simple(8'h06);
        cs_on();
        hdr(8'h02, 24'h000010);
        xfer(8'h00, d);
        for (int i = 0; i < 4; i++) begin
            mosi = 1'b0;
            #HALF;
            sck = 1'b1;
            #HALF;
            sck = 1'b0;
        end
        cs_off();
        status("R10 partial program not committed", 8'h02);
        read1("R10 array unchanged after abort", 24'h000010, 8'hFF);
        simple(8'h04);

        // R9 commands ignored while busy; R3 other sector untouched
        erase(24'h000400);
        simple(8'h04);
        status("R9 write disable ignored while busy", 8'h03);
        read1("R9 read ignored while busy", 24'h000000, 8'hFF);
        settle();
        status("R9 erase finished normally", 8'h00);
        read1("R3 neighbour sector untouched", 24'h000000, 8'h40);
        read1("R3 target sector erased", 24'h000400, 8'hFF);

        // R11 upper address bits ignored
        read1("R11 aliased address", 24'h100000, 8'h40);

        // R12 reset clears WEL
        simple(8'h06);
        status("R2 WEL set before reset", 8'h02);
        @(negedge clk);
        rst_n = 1'b0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        status("R12 WEL cleared by reset", 8'h00);
        check("R12 miso high after reset", {7'b0, miso}, 8'h01);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end
endmodule